// File: doc/BRIEF.md
# Shiftable Display Address Counter

This block keeps two base pointers for a multiplexed dot-matrix display: a 6-bit base into a 64-entry character-code memory and a 4-bit base into a 16-entry extra-dot memory. During the display scan it turns the current digit number (1 to 16) into one read address for each memory. The address is the base plus the digit offset, wrapped to the memory size.

A host command path can load both bases at once. It can also rotate either base, or both, one position left or right, which scrolls the visible window over the stored text. Commands first update a pending copy of each base. The pending copy moves into the active base only on a frame-start pulse, so the addresses never change part way through a scan frame. The serial command decoder and the memories themselves sit outside this block.

Top module: `disp_addr_ctr`

## Requirements
- R1: When `load_en` is high, both pending bases take `load_char_base` and `load_dot_base`.
- R2: With active character base Bc and active dot base Bd, digit n (1..16) gives `char_addr` = (Bc + n - 1) mod 64 and `dot_addr` = (Bd + n - 1) mod 16.
- R3: A right shift (`shift_left` = 0) adds 1 to each selected pending base, wrapping from 63 to 0 for the character base and from 15 to 0 for the dot base.
- R4: A left shift (`shift_left` = 1) subtracts 1 from each selected pending base, wrapping from 0 to 63 for the character base and from 0 to 15 for the dot base.
- R5: During a shift, `shift_sel_char` selects the character base and `shift_sel_dot` selects the dot base. Either one, both or neither may be set. A base that is not selected keeps its value.
- R6: The active bases change only on a clock edge where `frame_start` is high. At that edge they take the pending value, including the effect of any command presented in the same cycle.
- R7: If `load_en` and `shift_en` are high in the same cycle, the load applies and the shift is ignored.
- R8: A synchronous `rst` clears the pending bases, the active bases and both address outputs to zero.
- R9: Both address outputs are registered. Each reflects the digit and the active bases present on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load both bases this cycle |
| load_char_base | input | 6 | Character base value to load |
| load_dot_base | input | 4 | Dot base value to load |
| shift_en | input | 1 | Rotate the selected bases this cycle |
| shift_sel_char | input | 1 | Shift applies to the character base |
| shift_sel_dot | input | 1 | Shift applies to the dot base |
| shift_left | input | 1 | 1 = left (decrement), 0 = right (increment) |
| frame_start | input | 1 | Commit pending bases to active |
| scan_digit | input | 5 | Current scan digit, 1..16 |
| char_addr | output | 6 | Character memory read address |
| dot_addr | output | 4 | Dot memory read address |

## Verification
A behavioural model in the bench predicts both addresses and is compared with the outputs on every clock. The stimulus sweeps all 16 digits under loaded bases near both wrap points, which separates correct modulo arithmetic from overflow into a wider sum. Runs of left shifts, runs of right shifts and every select combination show whether each base moves on its own and in the right direction. Commands issued between frame pulses, and commands issued in the same cycle as a frame pulse, show whether the commit timing is correct. A load and a shift in the same cycle checks the priority.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic left;
  } base_cmd_t;
endpackage

// File: rtl/base_reg.sv
module base_reg #(
  parameter int AW = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  disp_addr_pkg::base_cmd_t cmd,
  input  logic                     sel,
  input  logic [AW-1:0]            load_val,
  input  logic                     frame_start,
  output logic [AW-1:0]            active
);
  logic [AW-1:0] pend, pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (cmd.load)
      pend_nxt = load_val;
    else if (cmd.shift && sel)
      pend_nxt = cmd.left ? pend - AW'(1) : pend + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      active <= '0;
    end else begin
      pend <= pend_nxt;
      if (frame_start) active <= pend_nxt;
    end
  end

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (pend == '0 && active == '0));
  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> pend == $past(load_val));
  a_r3_right: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && cmd.shift && sel && !cmd.left) |=> pend == AW'($past(pend) + 1'b1));
  a_r4_left: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && cmd.shift && sel && cmd.left) |=> pend == AW'($past(pend) - 1'b1));
  a_r5_unselected: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !sel) |=> $stable(pend));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(active));
endmodule

// File: rtl/addr_map.sv
module addr_map #(
  parameter int AW = 6,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] digit,
  output logic [AW-1:0] addr
);
  localparam int SW = (AW > DW) ? AW : DW;
  logic [SW-1:0] sum;

  always_comb sum = SW'(base) + SW'(digit) - SW'(1);

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else     addr <= sum[AW-1:0];
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && digit == DW'($past(digit) + 1'b1) && base == $past(base))
      |=> addr == AW'($past(addr) + 1'b1));
  a_r9_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(digit) && $stable(base)) |=> $stable(addr));
endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr #(
  parameter int CHAR_AW = 6,
  parameter int DOT_AW  = 4,
  parameter int DIG_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [CHAR_AW-1:0] load_char_base,
  input  logic [DOT_AW-1:0]  load_dot_base,
  input  logic               shift_en,
  input  logic               shift_sel_char,
  input  logic               shift_sel_dot,
  input  logic               shift_left,
  input  logic               frame_start,
  input  logic [DIG_W-1:0]   scan_digit,
  output logic [CHAR_AW-1:0] char_addr,
  output logic [DOT_AW-1:0]  dot_addr
);
  disp_addr_pkg::base_cmd_t cmd;
  logic [CHAR_AW-1:0] char_base;
  logic [DOT_AW-1:0]  dot_base;

  // R7: load has priority, so the shift flag is masked by load
  always_comb begin
    cmd.load  = load_en;
    cmd.shift = shift_en && !load_en;
    cmd.left  = shift_left;
  end

  base_reg #(.AW(CHAR_AW)) u_char_base (
    .clk(clk), .rst(rst), .cmd(cmd), .sel(shift_sel_char),
    .load_val(load_char_base), .frame_start(frame_start), .active(char_base));

  base_reg #(.AW(DOT_AW)) u_dot_base (
    .clk(clk), .rst(rst), .cmd(cmd), .sel(shift_sel_dot),
    .load_val(load_dot_base), .frame_start(frame_start), .active(dot_base));

  addr_map #(.AW(CHAR_AW), .DW(DIG_W)) u_char_map (
    .clk(clk), .rst(rst), .base(char_base), .digit(scan_digit), .addr(char_addr));

  addr_map #(.AW(DOT_AW), .DW(DIG_W)) u_dot_map (
    .clk(clk), .rst(rst), .base(dot_base), .digit(scan_digit), .addr(dot_addr));
endmodule

// File: tb/disp_addr_ctr_tb.sv
module disp_addr_ctr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 0, shift_en = 0, sel_c = 0, sel_d = 0, left = 0, fs = 0;
  logic [5:0] lc = 0;
  logic [3:0] ld = 0;
  logic [4:0] digit = 5'd1;
  logic [5:0] char_addr;
  logic [3:0] dot_addr;

  always #2.5 clk = ~clk;

  disp_addr_ctr dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_char_base(lc),
    .load_dot_base(ld), .shift_en(shift_en), .shift_sel_char(sel_c),
    .shift_sel_dot(sel_d), .shift_left(left), .frame_start(fs),
    .scan_digit(digit), .char_addr(char_addr), .dot_addr(dot_addr));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R8";
  bit done = 0;

  // behavioural reference model
  int pc = 0, pd = 0, ac = 0, ad = 0, ec = 0, ed = 0;
  always @(posedge clk) begin
    int nc, nd;
    if (rst) begin
      pc = 0; pd = 0; ac = 0; ad = 0; ec = 0; ed = 0;
    end else begin
      nc = pc; nd = pd;
      if (load_en) begin nc = lc; nd = ld; end
      else if (shift_en) begin
        if (sel_c) nc = left ? (nc + 63) % 64 : (nc + 1) % 64;
        if (sel_d) nd = left ? (nd + 15) % 16 : (nd + 1) % 16;
      end
      ec = (ac + digit - 1) % 64;
      ed = (ad + digit - 1) % 16;
      pc = nc; pd = nd;
      if (fs) begin ac = nc; ad = nd; end
    end
  end

  always @(negedge clk) if (!done) begin
    n_chk++;
    if (char_addr !== ec[5:0] || dot_addr !== ed[3:0]) begin
      n_fail++;
      $display("FAIL %s: char_addr=%0d dot_addr=%0d expected %0d %0d",
               cur_req, char_addr, dot_addr, ec, ed);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    load_en = 0; shift_en = 0; fs = 0;
  endtask

  task automatic scan_frame();
    fs = 1; digit = 5'd1; tick(); fs = 0;
    for (int i = 2; i <= 16; i++) begin digit = 5'(i); tick(); end
    digit = 5'd1;
  endtask

  task automatic do_load(input logic [5:0] c, input logic [3:0] d);
    load_en = 1; lc = c; ld = d; tick(); idle();
  endtask

  task automatic do_shift(input logic l, input logic sc, input logic sd);
    shift_en = 1; left = l; sel_c = sc; sel_d = sd; tick(); idle();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    cur_req = "R8"; tick(); tick();
    cur_req = "R2"; scan_frame();
    cur_req = "R1"; do_load(6'd60, 4'd14); scan_frame();
    cur_req = "R6"; do_load(6'd5, 4'd3);
    for (int i = 1; i <= 16; i++) begin digit = 5'(i); tick(); end
    scan_frame();
    cur_req = "R3";
    do_load(6'd62, 4'd15); scan_frame();
    for (int k = 0; k < 3; k++) begin do_shift(0, 1, 1); scan_frame(); end
    cur_req = "R4";
    do_load(6'd1, 4'd1); scan_frame();
    for (int k = 0; k < 3; k++) begin do_shift(1, 1, 1); scan_frame(); end
    cur_req = "R5";
    do_shift(1, 1, 0); scan_frame();
    do_shift(0, 0, 1); scan_frame();
    do_shift(0, 0, 0); scan_frame();
    cur_req = "R7";
    load_en = 1; lc = 6'd20; ld = 4'd7; shift_en = 1; sel_c = 1; sel_d = 1; left = 0;
    tick(); idle(); scan_frame();
    cur_req = "R6";
    shift_en = 1; sel_c = 1; sel_d = 1; left = 1; fs = 1; digit = 5'd1; tick(); idle();
    for (int i = 2; i <= 16; i++) begin digit = 5'(i); tick(); end
    scan_frame();
    cur_req = "R9";
    for (int i = 16; i >= 1; i--) begin digit = 5'(i); tick(); end
    cur_req = "R8";
    rst = 1; tick(); rst = 0; digit = 5'd1; tick(); tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule